// File: doc/BRIEF.md
# Effective Address Sequencer for an 8-bit Processor

This unit sits beside the decode logic of a small 8-bit processor core. Given an addressing-mode code, the one or two operand bytes that followed the opcode, and the current X and Y index values, it works out the 16-bit effective address of the operand. When the mode needs a pointer from memory, it reads the pointer bytes itself through a one-byte synchronous read port. It applies the historical wrap rules. Page-zero arithmetic never leaves page zero. The indirect jump fetches the high pointer byte from the start of the same page when the low pointer byte sits at offset 0xFF.

The unit also settles the timing penalty. Read accesses in absolute-indexed and indirect-indexed modes take an extra cycle only when adding the index changes the high address byte. Stores and read-modify-write accesses in those modes always take it. In the absolute-indexed penalty cycle a throw-away read goes to the unindexed base address.

A transaction begins with a one-cycle `start` pulse while the sequencer is idle. It ends with a one-cycle `done` pulse. While `done` is high, the address, the page-cross flag and the penalty flag are valid.

States:
- `S_IDLE`: waits for `start`.
- `S_PTR_LO`: reads the low pointer byte.
- `S_PTR_HI`: reads the high pointer byte.
- `S_PTR_END`: combines the pointer with the index.
- `S_PENALTY`: the extra cycle.
- `S_FINISH`: raises `done`.

Transitions:
- `S_IDLE` goes to `S_PTR_LO` on `start` for the three pointer modes.
- `S_IDLE` goes to `S_PENALTY` on `start` when the penalty applies.
- `S_IDLE` goes to `S_FINISH` on `start` otherwise.
- `S_PTR_LO` goes to `S_PTR_HI`.
- `S_PTR_HI` goes to `S_PTR_END`.
- `S_PTR_END` goes to `S_PENALTY` when the penalty applies, and to `S_FINISH` otherwise.
- `S_PENALTY` goes to `S_FINISH`.
- `S_FINISH` goes to `S_IDLE`.

Top module: `ea_sequencer`

## Requirements
- R1: After reset, `done` and `mem_rd` are low and the unit is idle.
- R2: The mode codes are: 0 absolute, 1 absolute+X, 2 absolute+Y, 3 page zero, 4 page zero+X, 5 page zero+Y, 6 indexed indirect (X), 7 indirect indexed (Y), 8 indirect jump. Codes 9 to 15 behave as code 0. Absolute gives `{op_hi, op_lo}`, with `done` in the first cycle after the cycle that sampled `start`, and with no memory read.
- R3: Page-zero modes give `{0x00, (op_lo + index) mod 256}`, where the index is 0 for code 3. `done` comes after 1 cycle and there is no memory read.
- R4: Absolute+X and absolute+Y give `{op_hi, op_lo} + index` over 16 bits. `page_cross` equals the carry out of `op_lo + index`.
- R5: In modes 1, 2 and 7, `penalty` is high exactly when `page_cross` or `is_write` is high. The penalty adds one cycle to the latency. In all other modes `penalty` and `page_cross` are low.
- R6: In modes 1 and 2, the penalty cycle issues exactly one read, to `{op_hi, op_lo}`. Without a penalty, no read is issued.
- R7: Mode 6 reads `{0x00, p}` and then `{0x00, (p+1) mod 256}`, where p = `(op_lo + X) mod 256`. The result is `{second byte, first byte}`, with `done` after 4 cycles.
- R8: Mode 7 reads `{0x00, op_lo}` and then `{0x00, (op_lo+1) mod 256}`. The result is the 16-bit pointer plus Y. `page_cross` is the carry out of pointer-low + Y. `done` comes after 4 cycles, or 5 with the penalty.
- R9: Mode 8 reads `{op_hi, op_lo}` and then `{op_hi, (op_lo+1) mod 256}`, keeping the page unchanged. The result is `{second byte, first byte}`, with `done` after 4 cycles.
- R10: `done` is high for exactly one cycle per transaction. The memory data for a read appears on `mem_rdata` in the following cycle.
- R11: A `start` pulse arriving while a transaction is in progress is ignored. The running result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| mode | input | 4 | Addressing-mode code (see R2) |
| is_write | input | 1 | Access is a store or read-modify-write |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address (valid with `done`) |
| page_cross | output | 1 | Index addition changed the high byte |
| penalty | output | 1 | Extra cycle was taken |

## Verification
The bench aims at each wrap point in turn:
- Page-zero sums past 0xFF must fold back to page zero instead of spilling into page one.
- An indexed-indirect pointer at 0xFF must take its high byte from 0x00.
- An indirect-jump pointer at offset 0xFF must stay on its page rather than step to the next one, which is the classic defect this block has to reproduce.
- Indexed accesses mix crossing and non-crossing sums with reads and writes. A design that charges reads without a cross, or lets writes skip the penalty, shows up as a wrong latency or a wrong `penalty` flag.
- The stray base-address read is counted exactly, so a missing read or one issued to the indexed address is caught.
- Late `start` pulses with altered inputs are injected into pointer transactions; a design that restarts on them returns the wrong address.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;
    localparam logic [3:0] AM_ABS   = 4'd0;
    localparam logic [3:0] AM_ABS_X = 4'd1;
    localparam logic [3:0] AM_ABS_Y = 4'd2;
    localparam logic [3:0] AM_ZP    = 4'd3;
    localparam logic [3:0] AM_ZP_X  = 4'd4;
    localparam logic [3:0] AM_ZP_Y  = 4'd5;
    localparam logic [3:0] AM_IND_X = 4'd6;
    localparam logic [3:0] AM_IND_Y = 4'd7;
    localparam logic [3:0] AM_IND   = 4'd8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR_LO,
        S_PTR_HI,
        S_PTR_END,
        S_PENALTY,
        S_FINISH
    } seq_state_e;
endpackage

// File: rtl/ea_index_add.sv
module ea_index_add #(
    parameter int DW = 8
) (
    input  logic [2*DW-1:0] base,
    input  logic [DW-1:0]   idx,
    input  logic            zp_wrap,
    output logic [2*DW-1:0] sum,
    output logic            carry
);
    logic [DW:0] lo_sum;

    assign lo_sum = {1'b0, base[DW-1:0]} + {1'b0, idx};

    always_comb begin
        if (zp_wrap) begin
            // page-zero arithmetic: carry discarded, high byte forced to zero
            sum   = {{DW{1'b0}}, lo_sum[DW-1:0]};
            carry = 1'b0;
        end else begin
            sum   = {base[2*DW-1:DW] + {{(DW-1){1'b0}}, lo_sum[DW]}, lo_sum[DW-1:0]};
            carry = lo_sum[DW];
        end
    end
endmodule

// File: rtl/ea_penalty_rule.sv
module ea_penalty_rule (
    input  logic [3:0] mode,
    input  logic       is_write,
    input  logic       carry,
    output logic       take
);
    import ea_seq_pkg::*;

    logic indexed;

    always_comb begin
        indexed = (mode == AM_ABS_X) || (mode == AM_ABS_Y) || (mode == AM_IND_Y);
        take    = indexed && (carry || is_write);
    end
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer #(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic              is_write,
    input  logic [DW-1:0]     op_lo,
    input  logic [DW-1:0]     op_hi,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    output logic              mem_rd,
    output logic [2*DW-1:0]   mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic              done,
    output logic [2*DW-1:0]   ea,
    output logic              page_cross,
    output logic              penalty
);
    import ea_seq_pkg::*;

    localparam int AW = 2 * DW;

    seq_state_e state, state_nx;

    logic [3:0]    mode_n, mode_q, mode_sel;
    logic          wr_q, wr_sel;
    logic [DW-1:0] y_q, lo_q;
    logic [AW-1:0] base_q, ptr_q, ea_q;
    logic          cross_q, pen_q;

    logic [DW-1:0] idx_s, idx_p;
    logic          zp_s;
    logic [AW-1:0] sum_s, sum_p;
    logic          carry_s, carry_p, carry_sel, pen_take;
    logic          ptr_mode;

    // undefined codes fall back to absolute
    assign mode_n = (mode > AM_IND) ? AM_ABS : mode;

    always_comb begin
        unique case (mode_n)
            AM_ABS_X, AM_ZP_X, AM_IND_X: idx_s = idx_x;
            AM_ABS_Y, AM_ZP_Y:           idx_s = idx_y;
            default:                     idx_s = '0;
        endcase
        zp_s     = (mode_n == AM_ZP) || (mode_n == AM_ZP_X) ||
                   (mode_n == AM_ZP_Y) || (mode_n == AM_IND_X);
        ptr_mode = (mode_n == AM_IND_X) || (mode_n == AM_IND_Y) || (mode_n == AM_IND);
        idx_p    = (mode_q == AM_IND_Y) ? y_q : '0;
    end

    ea_index_add #(.DW(DW)) u_add_start (
        .base    ({op_hi, op_lo}),
        .idx     (idx_s),
        .zp_wrap (zp_s),
        .sum     (sum_s),
        .carry   (carry_s)
    );

    ea_index_add #(.DW(DW)) u_add_ptr (
        .base    ({mem_rdata, lo_q}),
        .idx     (idx_p),
        .zp_wrap (1'b0),
        .sum     (sum_p),
        .carry   (carry_p)
    );

    always_comb begin
        if (state == S_IDLE) begin
            mode_sel  = mode_n;
            wr_sel    = is_write;
            carry_sel = carry_s;
        end else begin
            mode_sel  = mode_q;
            wr_sel    = wr_q;
            carry_sel = carry_p;
        end
    end

    ea_penalty_rule u_pen (
        .mode     (mode_sel),
        .is_write (wr_sel),
        .carry    (carry_sel),
        .take     (pen_take)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (ptr_mode)      state_nx = S_PTR_LO;
                    else if (pen_take) state_nx = S_PENALTY;
                    else               state_nx = S_FINISH;
                end
            end
            S_PTR_LO:  state_nx = S_PTR_HI;
            S_PTR_HI:  state_nx = S_PTR_END;
            S_PTR_END: state_nx = pen_take ? S_PENALTY : S_FINISH;
            S_PENALTY: state_nx = S_FINISH;
            S_FINISH:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= AM_ABS;
            wr_q    <= 1'b0;
            y_q     <= '0;
            lo_q    <= '0;
            base_q  <= '0;
            ptr_q   <= '0;
            ea_q    <= '0;
            cross_q <= 1'b0;
            pen_q   <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                mode_q  <= mode_n;
                wr_q    <= is_write;
                y_q     <= idx_y;
                base_q  <= {op_hi, op_lo};
                ea_q    <= sum_s;
                cross_q <= carry_s;
                pen_q   <= pen_take;
                if (mode_n == AM_IND_X)      ptr_q <= sum_s;
                else if (mode_n == AM_IND_Y) ptr_q <= {{DW{1'b0}}, op_lo};
                else                         ptr_q <= {op_hi, op_lo};
            end
            if (state == S_PTR_HI) lo_q <= mem_rdata;
            if (state == S_PTR_END) begin
                ea_q    <= sum_p;
                cross_q <= carry_p;
                pen_q   <= pen_take;
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd     = 1'b0;
        mem_addr   = '0;
        done       = 1'b0;
        ea         = '0;
        page_cross = 1'b0;
        penalty    = 1'b0;
        unique case (state)
            S_IDLE, S_PTR_END: ;
            S_PTR_LO: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_q;
            end
            S_PTR_HI: begin
                // the page byte is never incremented
                mem_rd   = 1'b1;
                mem_addr = {ptr_q[AW-1:DW], ptr_q[DW-1:0] + {{(DW-1){1'b0}}, 1'b1}};
            end
            S_PENALTY: begin
                mem_rd   = (mode_q == AM_ABS_X) || (mode_q == AM_ABS_Y);
                mem_addr = base_q;
            end
            S_FINISH: begin
                done       = 1'b1;
                ea         = ea_q;
                page_cross = cross_q;
                penalty    = pen_q;
            end
            default: ;
        endcase
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!mem_rd && !done));

    // R3
    zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == AM_ZP || mode_q == AM_ZP_X || mode_q == AM_ZP_Y))
        |-> (ea[AW-1:DW] == '0));

    // R7
    ptr_zp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && state != S_PENALTY && (mode_q == AM_IND_X || mode_q == AM_IND_Y))
        |-> (mem_addr[AW-1:DW] == '0));

    // R9
    ind_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PTR_HI) |-> (mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW])));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    penalty_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && penalty) |-> (page_cross || wr_q));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && start) |=> $stable(base_q));
endmodule

// File: tb/sim_ea_sequencer.sv
`timescale 1ns/1ps
module sim_ea_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        is_write = 1'b0;
    logic [7:0]  op_lo = 8'd0, op_hi = 8'd0, idx_x = 8'd0, idx_y = 8'd0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'd0;
    logic        done;
    logic [15:0] ea;
    logic        page_cross, penalty;

    int checks = 0;
    int errors = 0;
    logic        logging = 1'b0;
    logic [15:0] rd_log [0:7];
    int          rd_n = 0;

    always #2 clk = ~clk;

    ea_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_write(is_write),
        .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .ea(ea), .page_cross(page_cross), .penalty(penalty)
    );

    function automatic logic [7:0] byte_at(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ {a[10:8], a[15:11]} ^ 8'h3C;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= byte_at(mem_addr);

    always @(negedge clk) begin
        if (logging && mem_rd) begin
            if (rd_n < 8) rd_log[rd_n] = mem_addr;
            rd_n = rd_n + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] m, input logic wr, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] x, input logic [7:0] y,
                          input logic poke);
        logic [3:0]  mn;
        logic [15:0] e_ea, a1, a2, pb;
        logic        e_cross, e_pen;
        int          e_lat, e_nrd, lat;
        logic [8:0]  s9;
        mn = (m > 4'd8) ? 4'd0 : m;
        e_cross = 1'b0; e_pen = 1'b0; e_lat = 1; e_nrd = 0;
        a1 = 16'h0; a2 = 16'h0; e_ea = {hi, lo};
        case (mn)
            4'd3: e_ea = {8'h00, lo};
            4'd4: e_ea = {8'h00, lo + x};
            4'd5: e_ea = {8'h00, lo + y};
            4'd1, 4'd2: begin
                s9 = {1'b0, lo} + {1'b0, (mn == 4'd1) ? x : y};
                e_cross = s9[8];
                e_ea = {hi, lo} + {8'h00, (mn == 4'd1) ? x : y};
                e_pen = e_cross | wr;
                e_lat = e_pen ? 2 : 1;
                if (e_pen) begin e_nrd = 1; a1 = {hi, lo}; end
            end
            4'd6: begin
                a1 = {8'h00, lo + x}; a2 = {8'h00, lo + x + 8'd1};
                e_ea = {byte_at(a2), byte_at(a1)}; e_lat = 4; e_nrd = 2;
            end
            4'd7: begin
                a1 = {8'h00, lo}; a2 = {8'h00, lo + 8'd1};
                pb = {byte_at(a2), byte_at(a1)};
                s9 = {1'b0, pb[7:0]} + {1'b0, y};
                e_cross = s9[8]; e_ea = pb + {8'h00, y};
                e_pen = e_cross | wr; e_lat = e_pen ? 5 : 4; e_nrd = 2;
            end
            4'd8: begin
                a1 = {hi, lo}; a2 = {hi, lo + 8'd1};
                e_ea = {byte_at(a2), byte_at(a1)}; e_lat = 4; e_nrd = 2;
            end
            default: ;
        endcase

        @(negedge clk);
        mode = m; is_write = wr; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y;
        start = 1'b1; rd_n = 0; logging = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) start = 1'b0;
            if (poke && lat == 2) begin
                // R11 stray start with altered inputs
                start = 1'b1; mode = 4'd0; op_lo = ~lo; op_hi = ~hi;
            end
            if (lat == 3) start = 1'b0;
        end while (!done && lat < 20);
        logging = 1'b0;

        chk(lat == e_lat, (mn == 4'd7) ? "R8 latency" : (mn >= 4'd6) ? "R7/R9 latency" :
            (mn == 4'd1 || mn == 4'd2) ? "R5 latency" : "R2/R3 latency", lat, e_lat);
        chk(ea == e_ea, (mn == 4'd6) ? "R7 ea" : (mn == 4'd7) ? "R8 ea" : (mn == 4'd8) ? "R9 ea" :
            (mn == 4'd1 || mn == 4'd2) ? "R4 ea" : "R2/R3 ea", ea, e_ea);
        chk(page_cross == e_cross, "R4 page_cross", page_cross, e_cross);
        chk(penalty == e_pen, "R5 penalty", penalty, e_pen);
        chk(rd_n == e_nrd, "R6 read count", rd_n, e_nrd);
        if (e_nrd >= 1 && rd_n >= 1) chk(rd_log[0] == a1, "R6/R7/R8/R9 first read", rd_log[0], a1);
        if (e_nrd == 2 && rd_n >= 2) chk(rd_log[1] == a2, "R7/R8/R9 second read", rd_log[1], a2);
        @(negedge clk);
        chk(done == 1'b0, "R10 done pulse", done, 0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7421));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(mem_rd == 1'b0, "R1 mem_rd after reset", mem_rd, 0);

        // directed corners
        run_op(4'd0, 1'b0, 8'h34, 8'h12, 8'h00, 8'h00, 1'b0);   // R2 absolute
        run_op(4'd12, 1'b0, 8'hCD, 8'hAB, 8'h55, 8'h66, 1'b0);  // R2 undefined code
        run_op(4'd3, 1'b1, 8'h80, 8'h77, 8'h10, 8'h10, 1'b0);   // R3 page zero
        run_op(4'd4, 1'b0, 8'hF0, 8'h12, 8'h20, 8'h00, 1'b0);   // R3 wrap 0x0010
        run_op(4'd5, 1'b0, 8'hFF, 8'h12, 8'h00, 8'hFF, 1'b0);   // R3 wrap
        run_op(4'd1, 1'b0, 8'hF0, 8'h20, 8'h20, 8'h00, 1'b0);   // R4 cross read
        run_op(4'd1, 1'b0, 8'h10, 8'h20, 8'h20, 8'h00, 1'b0);   // R5 no cross read
        run_op(4'd2, 1'b1, 8'h10, 8'h20, 8'h00, 8'h05, 1'b0);   // R6 write penalty
        run_op(4'd2, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h01, 1'b0);   // R4 16-bit wrap
        run_op(4'd6, 1'b0, 8'hF0, 8'h00, 8'h0F, 8'h00, 1'b0);   // R7 pointer at 0xFF
        run_op(4'd7, 1'b0, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0);   // R8 pointer at 0xFF
        run_op(4'd7, 1'b1, 8'h40, 8'h00, 8'h00, 8'h00, 1'b0);   // R8 write penalty
        run_op(4'd8, 1'b0, 8'hFF, 8'h30, 8'h00, 8'h00, 1'b0);   // R9 page wrap defect
        run_op(4'd8, 1'b0, 8'hFF, 8'h30, 8'h00, 8'h00, 1'b1);   // R11 ignored start
        run_op(4'd6, 1'b0, 8'h22, 8'h00, 8'h11, 8'h00, 1'b1);   // R11 ignored start

        for (int i = 0; i < 400; i++) begin
            logic [3:0] m;
            logic       pk;
            m  = 4'($urandom % 16);
            pk = (m >= 4'd6 && m <= 4'd8) ? 1'($urandom % 2) : 1'b0;
            run_op(m, 1'($urandom % 2), 8'($urandom), 8'($urandom),
                   8'($urandom), 8'($urandom), pk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule